// File: doc/BRIEF.md
# Ternary Request-Embedded Line Encoder

This block turns one or more binary data streams into ternary line symbols. The request timing travels inside the symbol stream itself, so no separate strobe wire is needed. Each symbol period has two halves. In the first half the line carries the data value, true or false. In the second half the line returns to a middle "spacer" level. A receiver therefore sees a level change for every datum, and it needs no matched delay between a data wire and a clock wire. When the connection controller withholds the transmit enable, the line rests at spacer. The first datum after enable rises then shows up as a change from spacer to data.

The two halves of the slow clock are modelled with a clock at twice the symbol rate and an internal phase bit. This keeps the whole design on rising edges only. The bit and the enable are captured at the edge that opens a data half. They are held through that half and the spacer half that follows, so a change on either input never cuts a symbol short. A parameter sets how many independent lines share one enable. Each line has its own data bit and its own 2-bit symbol field.

Top module: `tern_line_enc`

## Requirements
- R1: While reset is asserted, and from reset release until the first data half, every lane's symbol is spacer (code 00).
- R2: In a data half with the captured enable high, a lane shows true (code 10) for a captured bit of 1 and false (code 01) for a captured bit of 0; code 11 never appears.
- R3: In every spacer half, every lane shows spacer (00), whatever the inputs are.
- R4: In a data half whose captured enable is low, every lane shows spacer (00).
- R5: The data bit is captured only at the edge that opens a data half; changes at other times do not alter the symbol on the line.
- R6: Enable is captured only at the edge that opens a data half; raising or dropping it at any other time neither starts nor truncates a symbol.
- R7: A lane fed the bits 0,1,0,1 with enable high produces the per-half sequence false, spacer, true, spacer, false, spacer, true, spacer.
- R8: Lanes are independent: the symbol on lane k depends only on bit k and the shared enable.
- R9: Halves alternate strictly after reset: the first clock edge after release opens a data half, and every non-spacer symbol is followed by a spacer on the next cycle.
- R10: After a run of disabled symbols, the first enabled datum appears as a change from spacer to a data code, at the first data half after enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each symbol takes two cycles (data half, then spacer half) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the connection controller, shared by all lanes |
| tx_bit | input | LANES | Binary data bit per lane |
| line_sym | output | 2*LANES | Ternary symbol per lane, lane k at bits [2k+1:2k]: 00 spacer, 01 false, 10 true |

## Verification
The bench builds the encoder with LANES set to 2. With two lanes it can drive different bits onto neighbouring lanes in the same symbol, which shows lane independence and field placement. The same build exercises the shared enable gating both lanes together. Toggling the inputs during spacer halves and in the middle of data halves reaches the capture-window corner cases. A reset applied in the middle of a data half shows the line snapping back to idle.

// File: rtl/tle_pkg.sv
package tle_pkg;

    // Two-bit ternary line code shared with the receiving queue.
    typedef enum logic [1:0] {
        SYM_SPACER = 2'b00,
        SYM_FALSE  = 2'b01,
        SYM_TRUE   = 2'b10
    } sym_t;

    localparam int SYM_W = 2;

    // Sequencer state: phase bit and the enable held for the current symbol.
    typedef struct packed {
        logic data_half;
        logic en_held;
    } seq_state_t;

    function automatic sym_t encode_bit(input logic bit_val);
        return bit_val ? SYM_TRUE : SYM_FALSE;
    endfunction

endpackage

// File: rtl/tle_phase_seq.sv
module tle_phase_seq
    import tle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic data_half,
    output logic open_strobe,
    output logic en_held
);

    seq_state_t st_d, st_q;

    // The coming edge opens a data half whenever the current half is a spacer.
    always_comb begin
        st_d           = st_q;
        st_d.data_half = ~st_q.data_half;
        if (!st_q.data_half) begin
            st_d.en_held = tx_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_half   = st_q.data_half;
    assign open_strobe = ~st_q.data_half;
    assign en_held     = st_q.en_held;

endmodule

// File: rtl/tle_lane_reg.sv
module tle_lane_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bit_in,
    output logic bit_held
);

    typedef struct packed {
        logic val;
    } lane_state_t;

    lane_state_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (load) begin
            ln_d.val = bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign bit_held = ln_q.val;

endmodule

// File: rtl/tle_sym_map.sv
module tle_sym_map
    import tle_pkg::*;
(
    input  logic data_half,
    input  logic en_held,
    input  logic bit_held,
    output logic [SYM_W-1:0] sym
);

    sym_t sym_d;

    always_comb begin
        sym_d = SYM_SPACER;
        if (data_half && en_held) begin
            sym_d = encode_bit(bit_held);
        end
    end

    assign sym = sym_d;

endmodule

// File: rtl/tern_line_enc.sv
module tern_line_enc
    import tle_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_en,
    input  logic [LANES-1:0]       tx_bit,
    output logic [SYM_W*LANES-1:0] line_sym
);

    localparam int OUT_W = SYM_W * LANES;

    logic data_half;
    logic open_strobe;
    logic en_held;
    logic [LANES-1:0] bit_held;
    logic [OUT_W-1:0] sym_bus;

    tle_phase_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .data_half   (data_half),
        .open_strobe (open_strobe),
        .en_held     (en_held)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tle_lane_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (open_strobe),
            .bit_in   (tx_bit[g]),
            .bit_held (bit_held[g])
        );

        tle_sym_map u_map (
            .data_half (data_half),
            .en_held   (en_held),
            .bit_held  (bit_held[g]),
            .sym       (sym_bus[SYM_W*g +: SYM_W])
        );
    end

    assign line_sym = sym_bus;

endmodule

// File: rtl/tern_line_enc_chk.sv
module tern_line_enc_chk #(
    parameter int LANES = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_en,
    input logic [LANES-1:0]     tx_bit,
    input logic [2*LANES-1:0]   line_sym,
    input logic                 phase
);

    // R1: idle line whenever reset is held
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> line_sym == '0);

    // R3: spacer halves are always spacer on every lane
    a_r3_spacer_half: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |-> line_sym == '0);

    // R4: a data half opened with enable low stays idle
    a_r4_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !$past(tx_en)) |-> line_sym == '0);

    // R9: data half is always followed by a spacer half
    a_r9_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> !phase);

    // R9: no two consecutive non-spacer symbols
    a_r9_spacer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sym != '0) |=> (line_sym == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R2: data symbol reflects the bit captured at the opening edge
        a_r2_data_symbol: assert property (@(posedge clk) disable iff (!rst_n)
            (phase && $past(tx_en)) |->
                line_sym[2*g +: 2] == ($past(tx_bit[g]) ? 2'b10 : 2'b01));

        // R2: unused code never driven
        a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            line_sym[2*g +: 2] != 2'b11);
    end

endmodule

bind tern_line_enc tern_line_enc_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .line_sym (line_sym),
    .phase    (data_half)
);

// File: tb/tern_line_enc_tb.sv
module tern_line_enc_tb;

    localparam int L  = 2;
    localparam int OW = 2 * L;
    localparam int NV = 11;

    // {en, bit1, bit0, expected lane1 code, expected lane0 code}
    localparam logic [6:0] VEC [NV] = '{
        7'b1_00_0101,   // both false
        7'b1_11_1010,   // both true
        7'b1_01_0110,   // R8: lane1 false, lane0 true
        7'b1_10_1001,   // R8: lane1 true, lane0 false
        7'b0_11_0000,   // R4 disabled
        7'b0_00_0000,   // R4 disabled
        7'b1_10_1001,   // R10 first after idle
        7'b1_10_1001,   // R7 lane0 0
        7'b1_01_0110,   // R7 lane0 1
        7'b1_10_1001,   // R7 lane0 0
        7'b1_01_0110    // R7 lane0 1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic [L-1:0]  tx_bit = '0;
    logic [OW-1:0] line_sym;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tern_line_enc #(.LANES(L)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_bit   (tx_bit),
        .line_sym (line_sym)
    );

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Called at a negedge in a spacer half; returns the data and spacer halves.
    task automatic send(input logic en, input logic [L-1:0] bits,
                        output logic [OW-1:0] d_obs, output logic [OW-1:0] s_obs);
        tx_en  = en;
        tx_bit = bits;
        @(posedge clk);
        @(negedge clk);
        d_obs = line_sym;
        @(posedge clk);
        @(negedge clk);
        s_obs = line_sym;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [OW-1:0] d, s, prev;
        logic [1:0] stream [8];

        repeat (3) @(negedge clk);
        check("R1 in reset", line_sym, '0);
        rst_n = 1'b1;

        // Table walk
        prev = line_sym;
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][6], VEC[i][5:4], d, s);
            check(VEC[i][6] ? "R2/R8 data half" : "R4 disabled data half", d, VEC[i][3:0]);
            check("R3 spacer half", s, '0);
            if (i == 6) begin
                check("R10 spacer before first datum", prev, '0);
                check("R10 first datum non-spacer", {3'b000, d != '0}, 4'b0001);
            end
            if (i >= 7) begin
                stream[2*(i-7)]   = d[1:0];
                stream[2*(i-7)+1] = s[1:0];
            end
            prev = s;
        end
        // R7: lane0 stream f,s,t,s,f,s,t,s
        check("R7 alternating stream",
              {stream[0], stream[1], stream[2], stream[3]}, {2'b01, 2'b00, 2'b10, 2'b00});
        check("R7 alternating stream tail",
              {stream[4], stream[5], stream[6], stream[7]}, {2'b01, 2'b00, 2'b10, 2'b00});

        // R5: bit change mid data half does not alter symbol
        tx_en  = 1'b1;
        tx_bit = 2'b00;
        @(posedge clk);
        @(negedge clk);
        tx_bit = 2'b11;
        #1;
        check("R5 bit change mid data half", line_sym, 4'b0101);

        // R6: enable drop mid data half does not truncate symbol
        tx_en = 1'b0;
        #1;
        check("R6 enable drop mid data half", line_sym, 4'b0101);
        @(posedge clk);
        @(negedge clk);
        check("R3 spacer after held symbol", line_sym, '0);

        // R5: glitch during spacer half; value at opening edge wins
        tx_en  = 1'b1;
        tx_bit = 2'b11;
        #1;
        tx_bit = 2'b01;
        @(posedge clk);
        @(negedge clk);
        check("R5 bit captured at opening edge", line_sym, 4'b0110);

        // R6: enable raised during a disabled data half starts nothing early
        tx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R6 disabled data half", line_sym, '0);
        tx_en  = 1'b1;
        tx_bit = 2'b10;
        @(posedge clk);
        @(negedge clk);
        check("R6 raised enable waits for opening edge", line_sym, '0);
        @(posedge clk);
        @(negedge clk);
        check("R6 enable taken at opening edge", line_sym, 4'b1001);

        // R1: reset mid data half returns line to idle
        rst_n = 1'b0;
        #1;
        check("R1 reset mid data half", line_sym, '0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 idle after release", line_sym, '0);

        // R9: first edge after release opens a data half
        tx_en  = 1'b1;
        tx_bit = 2'b01;
        @(posedge clk);
        @(negedge clk);
        check("R9 first edge opens data half", line_sym, 4'b0110);
        @(posedge clk);
        @(negedge clk);
        check("R9 spacer follows data", line_sym, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule